// File: doc/BRIEF.md
# Snooping Write-Back Coherence Controller

This block is the coherence controller of one private, direct-mapped, write-back cache on a shared bus with other caches. Each line is Invalid, Shared (clean, read-only) or Exclusive (dirty, sole copy, writable). Processor reads and writes that hit complete locally. Misses are turned into bus transactions that are issued once an external arbiter grants the bus. A dirty victim is written back before the miss that replaces it.

At the same time the controller watches every miss that other caches put on the bus. A snooped write miss removes the local copy. A snooped read miss demotes a dirty copy to Shared. Whenever the local copy is dirty, the controller supplies the line in the same cycle and raises an abort so that memory does not answer. Snoop lookups use their own copy of the tag and state arrays, so a snoop never steals a cycle from a processor hit at another index.

Line index is `cpuAddr[IDX_W-1:0]` and the tag is the remaining upper address bits. The bus command encoding is 00 none, 01 read miss, 10 write miss, 11 write-back.

Top module: `coh_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, and busReq, cpuReady and snpAbort are low.
- R2: A read whose line is Invalid or holds another tag raises busReq with busCmd 01 and busAddr = cpuAddr. In the cycle busGnt is high, cpuReady is high and cpuRdata equals busFill. The line then becomes Shared with that data.
- R3: A write whose line is not Exclusive with a matching tag raises busCmd 10 with busAddr = cpuAddr, including a write to a Shared line with a matching tag. cpuReady is high in the grant cycle. The line becomes Exclusive holding cpuWdata, and memory is not written.
- R4: A read matching a Shared or Exclusive line, or a write matching an Exclusive line, gives cpuReady in the first cycle of the request with no bus request. A write hit replaces the line data.
- R5: A miss whose line is Exclusive with another tag first issues busCmd 11, carrying the victim address {old tag, index} and the line data on busData. In the cycle after that grant it issues the read or write miss.
- R6: A snooped write miss (snpCmd 10) from another requester that matches a Shared line makes it Invalid without abort. If it matches an Exclusive line, snpAbort is high and snpData carries the line in that same cycle, and the line becomes Invalid.
- R7: A snooped read miss (snpCmd 01) from another requester that matches an Exclusive line raises snpAbort with the line on snpData in that cycle, and the line becomes Shared. A match on a Shared line changes nothing.
- R8: A snoop with snpId equal to MY_ID, with command 00 or 11, or whose tag differs, gives no abort and leaves the line unchanged.
- R9: A snoop that matches a line at the index of a request waiting for its grant drops busReq in the next cycle, and the lookup is redone. A victim flushed by the snoop is therefore not written back again.
- R10: A snoop that matches the index of a processor access in the same cycle holds cpuReady low for that cycle, and the access then proceeds on the updated state. A snoop at another index does not delay a hit.
- R11: An ungranted request keeps busReq, busCmd and busAddr unchanged while no snoop is on the bus. A grant never coincides with a snooped transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuValid | input | 1 | Processor request valid, held until cpuReady |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Processor line address |
| cpuWdata | input | DATA_W | Processor write data |
| cpuReady | output | 1 | Request completes this cycle |
| cpuRdata | output | DATA_W | Read data, valid with cpuReady |
| busReq | output | 1 | Bus request to the arbiter |
| busGnt | input | 1 | Grant; the transaction happens this cycle |
| busCmd | output | 2 | Command of the requested transaction |
| busId | output | ID_W | Requester id (MY_ID) |
| busAddr | output | ADDR_W | Line address of the transaction |
| busData | output | DATA_W | Write-back data |
| busFill | input | DATA_W | Line data returned in the grant cycle of a miss |
| snpCmd | input | 2 | Command of the snooped transaction |
| snpId | input | ID_W | Requester id of the snooped transaction |
| snpAddr | input | ADDR_W | Address of the snooped transaction |
| snpAbort | output | 1 | Local dirty copy supplies the line; memory must not respond |
| snpData | output | DATA_W | Dirty line data, valid with snpAbort |

## Verification
Two functions can meet in one cycle: a snooped miss and a processor lookup on the same index, and a snooped miss and a request that is still waiting for its grant. The bench provokes the first by presenting a snooped write miss in the exact cycle a read hit is requested. It judges the result by cpuReady staying low and a read miss following. It provokes the second by withholding the grant while a snooped read miss flushes the dirty victim. The pass criteria are the abort data, the dropped request, the reissued read miss with no second write-back, and memory holding the flushed value. A snoop at a different index in the same cycle as a hit checks that the duplicated tags keep the hit at full speed.

// File: rtl/coh_pkg.sv
`timescale 1ns/100ps
package coh_pkg;
  typedef enum logic [1:0] {ST_INV = 2'd0, ST_SHR = 2'd1, ST_EXC = 2'd2} lineSt_e;
  typedef enum logic [1:0] {CMD_NONE = 2'd0, CMD_RDMISS = 2'd1, CMD_WRMISS = 2'd2, CMD_WBACK = 2'd3} busCmd_e;
  typedef enum logic [1:0] {CS_IDLE = 2'd0, CS_WBACK = 2'd1, CS_MISS = 2'd2} ctlSt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    fillEn;      // write tag+state (+data) at processor index
    lineSt_e fillSt;
    logic    fillFromCpu; // fill data from cpuWdata instead of busFill
    logic    hitWrEn;     // write hit: replace data only
    logic    snpUpdEn;    // snoop changes state at snoop index
    lineSt_e snpNewSt;
  } dpCtl_t;
endpackage

// File: rtl/coh_datapath.sv
`timescale 1ns/100ps
module coh_datapath
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] busFill,
  input  logic [ADDR_W-1:0] snpAddr,
  output lineSt_e           cpuSt,
  output logic              cpuTagHit,
  output logic [DATA_W-1:0] cpuData,
  output logic [ADDR_W-1:0] victimAddr,
  output lineSt_e           snpSt,
  output logic              snpTagHit,
  output logic [DATA_W-1:0] snpData,
  output logic              idxClash
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int COPIES = 2; // copy 0 serves the processor, copy 1 the snooper

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;
  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  // identical tag/state copies, both written on every update
  for (genvar c = 0; c < COPIES; c++) begin : gCopy
    lineSt_e          stArr  [LINES];
    logic [TAG_W-1:0] tagArr [LINES];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < LINES; i++) stArr[i] <= ST_INV;
      end else begin
        if (ctl.snpUpdEn) stArr[snpIdx] <= ctl.snpNewSt;
        if (ctl.fillEn)   stArr[cpuIdx] <= ctl.fillSt;
      end
    end

    always_ff @(posedge clk) begin
      if (ctl.fillEn) tagArr[cpuIdx] <= cpuTag;
    end
  end

  logic [DATA_W-1:0] dataArr [LINES];
  always_ff @(posedge clk) begin
    if (ctl.fillEn)       dataArr[cpuIdx] <= ctl.fillFromCpu ? cpuWdata : busFill;
    else if (ctl.hitWrEn) dataArr[cpuIdx] <= cpuWdata;
  end

  assign cpuSt      = gCopy[0].stArr[cpuIdx];
  assign cpuTagHit  = (gCopy[0].tagArr[cpuIdx] == cpuTag);
  assign cpuData    = dataArr[cpuIdx];
  assign victimAddr = {gCopy[0].tagArr[cpuIdx], cpuIdx};
  assign snpSt      = gCopy[1].stArr[snpIdx];
  assign snpTagHit  = (gCopy[1].tagArr[snpIdx] == snpTag);
  assign snpData    = dataArr[snpIdx];
  assign idxClash   = (snpIdx == cpuIdx);
endmodule

// File: rtl/coh_control.sv
`timescale 1ns/100ps
module coh_control
  import coh_pkg::*;
#(
  parameter int ID_W  = 2,
  parameter int MY_ID = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cpuValid,
  input  logic            cpuWrite,
  input  lineSt_e         cpuSt,
  input  logic            cpuTagHit,
  input  logic            busGnt,
  input  logic [1:0]      snpCmd,
  input  logic [ID_W-1:0] snpId,
  input  lineSt_e         snpSt,
  input  logic            snpTagHit,
  input  logic            idxClash,
  output dpCtl_t          ctl,
  output logic            cpuReady,
  output logic            busReq,
  output logic [1:0]      busCmd,
  output logic            selVictim,
  output logic            rdFromBus,
  output logic            snpAbort
);
  ctlSt_e state, nextState;

  logic snpIsMiss, snpHit, clash, cpuHit;
  assign snpIsMiss = (snpCmd == CMD_RDMISS) || (snpCmd == CMD_WRMISS);
  assign snpHit    = snpIsMiss && (snpId != ID_W'(MY_ID)) && (snpSt != ST_INV) && snpTagHit;
  assign snpAbort  = snpHit && (snpSt == ST_EXC);
  assign clash     = snpHit && idxClash;
  assign cpuHit    = cpuTagHit && (cpuWrite ? (cpuSt == ST_EXC) : (cpuSt != ST_INV));

  always_comb begin
    ctl          = '0;
    ctl.fillSt   = ST_INV;
    ctl.snpUpdEn = snpHit && ((snpCmd == CMD_WRMISS) || (snpSt == ST_EXC));
    ctl.snpNewSt = (snpCmd == CMD_WRMISS) ? ST_INV : ST_SHR;
    nextState    = state;
    cpuReady     = 1'b0;
    busReq       = 1'b0;
    busCmd       = CMD_NONE;
    selVictim    = 1'b0;
    rdFromBus    = 1'b0;
    unique case (state)
      CS_IDLE: begin
        if (cpuValid && !clash) begin
          if (cpuHit) begin
            cpuReady    = 1'b1;
            ctl.hitWrEn = cpuWrite;
          end else begin
            nextState = (cpuSt == ST_EXC) ? CS_WBACK : CS_MISS;
          end
        end
      end
      CS_WBACK: begin
        busReq    = 1'b1;
        busCmd    = CMD_WBACK;
        selVictim = 1'b1;
        if (clash) nextState = CS_IDLE;
        else if (busGnt) begin
          ctl.fillEn = 1'b1;
          ctl.fillSt = ST_INV;
          nextState  = CS_MISS;
        end
      end
      CS_MISS: begin
        busReq    = 1'b1;
        busCmd    = cpuWrite ? CMD_WRMISS : CMD_RDMISS;
        rdFromBus = 1'b1;
        if (clash) nextState = CS_IDLE;
        else if (busGnt) begin
          ctl.fillEn      = 1'b1;
          ctl.fillSt      = cpuWrite ? ST_EXC : ST_SHR;
          ctl.fillFromCpu = cpuWrite;
          cpuReady        = 1'b1;
          nextState       = CS_IDLE;
        end
      end
      default: nextState = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= CS_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/coh_cache_ctrl.sv
`timescale 1ns/100ps
module coh_cache_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 8,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  input  logic              busGnt,
  output logic [1:0]        busCmd,
  output logic [ID_W-1:0]   busId,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData,
  input  logic [DATA_W-1:0] busFill,
  input  logic [1:0]        snpCmd,
  input  logic [ID_W-1:0]   snpId,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpAbort,
  output logic [DATA_W-1:0] snpData
);
  dpCtl_t            ctl;
  lineSt_e           cpuSt, snpSt;
  logic              cpuTagHit, snpTagHit, idxClash, selVictim, rdFromBus;
  logic [DATA_W-1:0] cpuData;
  logic [ADDR_W-1:0] victimAddr;

  coh_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .busFill(busFill), .snpAddr(snpAddr), .cpuSt(cpuSt), .cpuTagHit(cpuTagHit),
    .cpuData(cpuData), .victimAddr(victimAddr), .snpSt(snpSt),
    .snpTagHit(snpTagHit), .snpData(snpData), .idxClash(idxClash)
  );

  coh_control #(.ID_W(ID_W), .MY_ID(MY_ID)) uCtl (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuSt(cpuSt), .cpuTagHit(cpuTagHit), .busGnt(busGnt), .snpCmd(snpCmd),
    .snpId(snpId), .snpSt(snpSt), .snpTagHit(snpTagHit), .idxClash(idxClash),
    .ctl(ctl), .cpuReady(cpuReady), .busReq(busReq), .busCmd(busCmd),
    .selVictim(selVictim), .rdFromBus(rdFromBus), .snpAbort(snpAbort)
  );

  assign busId    = ID_W'(MY_ID);
  assign busAddr  = selVictim ? victimAddr : cpuAddr;
  assign busData  = cpuData;
  assign cpuRdata = rdFromBus ? busFill : cpuData;
endmodule

// File: rtl/coh_checker.sv
`timescale 1ns/100ps
module coh_checker #(
  parameter int ADDR_W = 8,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busGnt,
  input logic [1:0]        busCmd,
  input logic [ADDR_W-1:0] busAddr,
  input logic              cpuReady,
  input logic [1:0]        snpCmd,
  input logic [ID_W-1:0]   snpId,
  input logic              snpAbort
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGnt && snpCmd == 2'd0) |=> (busReq && $stable(busCmd) && $stable(busAddr))); // R11

  AST_ONE_XACT: assert property (@(posedge clk) disable iff (!rstN)
    busGnt |-> (snpCmd == 2'd0)); // R11

  AST_WB_THEN_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGnt && busCmd == 2'd3) |=> (busReq && busCmd != 2'd3)); // R5

  AST_GNT_COMPLETES: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGnt && busCmd != 2'd3) |-> cpuReady); // R2

  AST_ABORT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    snpAbort |-> ((snpCmd == 2'd1 || snpCmd == 2'd2) && snpId != ID_W'(MY_ID))); // R8
endmodule

bind coh_cache_ctrl coh_checker #(.ADDR_W(ADDR_W), .ID_W(ID_W), .MY_ID(MY_ID)) uChk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busGnt(busGnt), .busCmd(busCmd),
  .busAddr(busAddr), .cpuReady(cpuReady), .snpCmd(snpCmd), .snpId(snpId),
  .snpAbort(snpAbort)
);

// File: tb/tb_coh_cache_ctrl.sv
`timescale 1ns/100ps
module tb_coh_cache_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuValid = 1'b0, cpuWrite = 1'b0;
  logic [7:0]  cpuAddr = '0;
  logic [15:0] cpuWdata = '0;
  logic        cpuReady;
  logic [15:0] cpuRdata;
  logic        busReq;
  logic        busGnt = 1'b0;
  logic [1:0]  busCmd;
  logic [1:0]  busId;
  logic [7:0]  busAddr;
  logic [15:0] busData;
  logic [15:0] busFill = '0;
  logic [1:0]  snpCmd = '0;
  logic [1:0]  snpId = '0;
  logic [7:0]  snpAddr = '0;
  logic        snpAbort;
  logic [15:0] snpData;

  always #2.5 clk = ~clk;

  coh_cache_ctrl dut (.*);

  int nChecks = 0, nErr = 0;
  bit finished = 1'b0;

  // golden model: memory and this cache's lines (state 0 I, 1 S, 2 E)
  logic [15:0] mem [256];
  logic [4:0]  mTag [8];
  int          mSt [8];
  logic [15:0] mData [8];

  // stimulus table: [31:30] kind 0 rd/1 wr/2 snoop, [29:28] snoop cmd,
  // [27:26] snoop id, [23:16] address, [15:0] write data
  localparam logic [31:0] VEC [18] = '{
    32'h0010_0000, 32'h0010_0000, 32'h4010_AAAA, 32'h4010_BBBB,
    32'h0018_0000, 32'h4021_C001, 32'h9421_0000, 32'h0021_0000,
    32'hA821_0000, 32'h0021_0000, 32'h4022_D00D, 32'hAC22_0000,
    32'h4018_5555, 32'hA018_0000, 32'hB418_0000, 32'hA428_0000,
    32'h4018_6666, 32'h0022_0000
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doCpu(input bit wr, input logic [7:0] addr, input logic [15:0] data);
    int idx = int'(addr[2:0]);
    logic [4:0] tag = addr[7:3];
    bit hit = (mTag[idx] == tag) && (wr ? (mSt[idx] == 2) : (mSt[idx] != 0));
    bit expWb = !hit && (mSt[idx] == 2);
    int expN = hit ? 0 : (expWb ? 2 : 1);
    string req = hit ? "R4" : (wr ? "R3" : "R2");
    int nTx = 0, cyc = 0;
    bit done = 1'b0;
    logic [1:0] c1 = '0, cL = '0;
    logic [7:0] a1 = '0, aL = '0;
    logic [15:0] d1 = '0, rd = '0, expRd;
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = wr; cpuAddr = addr; cpuWdata = data;
    while (!done && cyc < 20) begin
      busGnt = 1'b0;
      if (busReq) begin
        nTx++;
        if (nTx == 1) begin c1 = busCmd; a1 = busAddr; d1 = busData; end
        cL = busCmd; aL = busAddr;
        if (busCmd == 2'd3) mem[busAddr] = busData;
        busFill = mem[busAddr];
        busGnt = 1'b1;
      end
      #1;
      cyc++;
      if (cpuReady) begin done = 1'b1; rd = cpuRdata; end
      @(posedge clk);
      if (!done) @(negedge clk);
    end
    @(negedge clk);
    cpuValid = 1'b0; busGnt = 1'b0;
    check(done, req, "access completes", 32'(done), 1);
    check(nTx == expN, req, "bus transaction count", nTx, expN);
    if (hit) check(cyc == 1, "R4", "hit ready in first cycle", cyc, 1);
    if (expWb) begin
      check(c1 == 2'd3, "R5", "victim write-back cmd", 32'(c1), 3);
      check(a1 == {mTag[idx], addr[2:0]}, "R5", "victim address", 32'(a1), 32'({mTag[idx], addr[2:0]}));
      check(d1 == mData[idx], "R5", "victim data", 32'(d1), 32'(mData[idx]));
    end
    if (!hit) begin
      check(cL == (wr ? 2'd2 : 2'd1), req, "miss cmd", 32'(cL), wr ? 2 : 1);
      check(aL == addr, req, "miss address", 32'(aL), 32'(addr));
    end
    if (!wr) begin
      expRd = hit ? mData[idx] : mem[addr];
      check(rd == expRd, req, "read data", 32'(rd), 32'(expRd));
    end
    if (wr) begin mSt[idx] = 2; mTag[idx] = tag; mData[idx] = data; end
    else if (!hit) begin mSt[idx] = 1; mTag[idx] = tag; mData[idx] = mem[addr]; end
  endtask

  task automatic doSnoop(input logic [1:0] cmd, input logic [1:0] id, input logic [7:0] addr);
    int idx = int'(addr[2:0]);
    bit hit = (id != 2'd0) && (cmd == 2'd1 || cmd == 2'd2) && (mSt[idx] != 0) && (mTag[idx] == addr[7:3]);
    bit expAbort = hit && (mSt[idx] == 2);
    string req = !hit ? "R8" : (cmd == 2'd2 ? "R6" : "R7");
    @(negedge clk);
    snpCmd = cmd; snpId = id; snpAddr = addr;
    #1;
    check(snpAbort == expAbort, req, "snoop abort", 32'(snpAbort), 32'(expAbort));
    if (expAbort) begin
      check(snpData == mData[idx], req, "snoop flush data", 32'(snpData), 32'(mData[idx]));
      mem[addr] = mData[idx];
    end
    @(posedge clk);
    @(negedge clk);
    snpCmd = 2'd0;
    if (hit && cmd == 2'd2) mSt[idx] = 0;
    else if (hit && mSt[idx] == 2) mSt[idx] = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nErr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h1000 + 16'(i * 7);
    for (int i = 0; i < 8; i++) begin mSt[i] = 0; mTag[i] = '0; mData[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1: reset state
    check(!busReq, "R1", "busReq after reset", 32'(busReq), 0);
    check(!cpuReady, "R1", "cpuReady after reset", 32'(cpuReady), 0);
    check(!snpAbort, "R1", "snpAbort after reset", 32'(snpAbort), 0);

    foreach (VEC[i]) begin
      logic [31:0] v = VEC[i];
      if (v[31:30] == 2'd2) doSnoop(v[29:28], v[27:26], v[23:16]);
      else doCpu(v[30], v[23:16], v[15:0]);
    end

    // R9: snoop flushes the victim while its write-back waits for the grant
    doCpu(1'b1, 8'h03, 16'h3333);
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = 1'b0; cpuAddr = 8'h0B;
    #1;
    check(!cpuReady, "R9", "miss not ready at lookup", 32'(cpuReady), 0);
    @(posedge clk); @(negedge clk);
    check(busReq && busCmd == 2'd3, "R9", "write-back requested", 32'({busReq, busCmd}), 32'h7);
    snpCmd = 2'd1; snpId = 2'd1; snpAddr = 8'h03;
    #1;
    check(snpAbort && snpData == 16'h3333, "R9", "flush during wait", 32'({snpAbort, snpData}), 32'h13333);
    mem[8'h03] = 16'h3333;
    @(posedge clk); @(negedge clk);
    snpCmd = 2'd0;
    check(!busReq, "R9", "request dropped after clash", 32'(busReq), 0);
    @(posedge clk); @(negedge clk);
    check(busReq && busCmd == 2'd1 && busAddr == 8'h0B, "R9", "read miss reissued without write-back",
          32'({busReq, busCmd, busAddr}), 32'({1'b1, 2'd1, 8'h0B}));
    busFill = mem[8'h0B]; busGnt = 1'b1;
    #1;
    check(cpuReady && cpuRdata == mem[8'h0B], "R9", "restarted miss completes",
          32'({cpuReady, cpuRdata}), 32'({1'b1, mem[8'h0B]}));
    @(posedge clk); @(negedge clk);
    busGnt = 1'b0; cpuValid = 1'b0;
    mSt[3] = 1; mTag[3] = 5'd1; mData[3] = mem[8'h0B];
    doCpu(1'b0, 8'h03, 16'h0); // R9: memory holds the flushed value

    // R10: same-index snoop in the cycle of a read hit
    doCpu(1'b0, 8'h04, 16'h0);
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = 1'b0; cpuAddr = 8'h04;
    snpCmd = 2'd2; snpId = 2'd2; snpAddr = 8'h04;
    #1;
    check(!cpuReady, "R10", "hit stalled by same-index snoop", 32'(cpuReady), 0);
    check(!snpAbort, "R10", "no abort on clean line", 32'(snpAbort), 0);
    @(posedge clk); @(negedge clk);
    snpCmd = 2'd0;
    #1;
    check(!cpuReady, "R10", "lookup after invalidation misses", 32'(cpuReady), 0);
    @(posedge clk); @(negedge clk);
    check(busReq && busCmd == 2'd1, "R10", "read miss after invalidation", 32'({busReq, busCmd}), 32'h5);
    busFill = mem[8'h04]; busGnt = 1'b1;
    #1;
    check(cpuReady && cpuRdata == mem[8'h04], "R10", "miss data", 32'(cpuRdata), 32'(mem[8'h04]));
    @(posedge clk); @(negedge clk);
    busGnt = 1'b0; cpuValid = 1'b0;
    mSt[4] = 1; mTag[4] = 5'd0; mData[4] = mem[8'h04];

    // R10: snoop at another index does not delay a hit
    @(negedge clk);
    cpuValid = 1'b1; cpuAddr = 8'h04;
    snpCmd = 2'd2; snpId = 2'd1; snpAddr = 8'h03;
    #1;
    check(cpuReady && cpuRdata == mData[4], "R10", "hit beside other-index snoop",
          32'({cpuReady, cpuRdata}), 32'({1'b1, mData[4]}));
    @(posedge clk); @(negedge clk);
    snpCmd = 2'd0; cpuValid = 1'b0;
    mSt[3] = 0;
    doCpu(1'b0, 8'h03, 16'h0); // R10: idx 3 was invalidated, so this misses

    // R11: ungranted request held stable
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = 1'b1; cpuAddr = 8'h05; cpuWdata = 16'h5A5A;
    @(posedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check(busReq && busCmd == 2'd2 && busAddr == 8'h05 && !cpuReady, "R11", "request held",
            32'({busReq, busCmd, busAddr}), 32'({1'b1, 2'd2, 8'h05}));
    end
    @(negedge clk);
    busGnt = 1'b1; busFill = mem[8'h05];
    #1;
    check(cpuReady, "R11", "completes on late grant", 32'(cpuReady), 1);
    @(posedge clk); @(negedge clk);
    busGnt = 1'b0; cpuValid = 1'b0;
    mSt[5] = 2; mTag[5] = 5'd0; mData[5] = 16'h5A5A;
    doSnoop(2'd1, 2'd3, 8'h05); // R7: flush of the written line

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule